// File: doc/BRIEF.md
# Accelerometer SPI Bring-Up and Sample Streamer

This block is an SPI master that starts up a three-axis digital accelerometer and then keeps pulling samples from it. After reset it holds chip select high for a programmable power-up delay. It then reads the identity register and compares the value with 0xE6. Next it writes three configuration registers in a fixed order. From then on it waits for interrupt edges.

Each low-to-high edge on the sensor's data-ready line starts one burst read of the six axis bytes, all inside a single chip-select frame. The bytes arrive low byte first. The block joins each pair into a signed 16-bit word and presents the X, Y and Z words together with a one-cycle valid strobe. A busy output marks every span in which the block is not free to accept an interrupt edge.

The serial link uses clock polarity 1 and phase 1. SCLK rests high, the master changes MOSI after each falling edge and samples MISO on each rising edge, and every byte goes MSB first. The `CLK_DIV` parameter sets the SCLK half-period in system clocks. The `WAIT_CYC` parameter sets the power-up delay in system clocks; its default of 110000 gives 1.1 ms at 100 MHz.

Top module: `accel_spi_ctrl`

## Requirements
- R1: Serial timing is mode 3. SCLK is high whenever chip select is inactive (high). SCLK falls only inside a frame. MISO is sampled on rising SCLK edges. Every byte travels MSB first.
- R2: After reset is released, chip select stays high for at least `WAIT_CYC` system clocks.
- R3: The first frame after the wait is two bytes long. Its command byte is 0x80, and a filler byte 0x00 follows it. The command byte is laid out as bit 7 = read, bit 6 = multi-byte, bits 5:0 = register address.
- R4: If the byte read back in the identity frame differs from 0xE6, `link_err` goes to 1. It stays at 1 until reset. If the byte equals 0xE6, `link_err` stays at 0.
- R5: After the identity frame come three two-byte write frames, in this order: (0x31, 0x0B), (0x2D, 0x08), (0x2E, 0x80). Each frame sends the command byte first and the data byte second. The setup writes run whether or not the identity matched.
- R6: Every register transaction has its own chip-select assertion. Chip select returns high between transactions.
- R7: Once setup is complete, a rising edge on `int1` starts one seven-byte frame. The frame is the command byte 0xF2 followed by six 0x00 filler bytes.
- R8: A burst is triggered by an edge, not a level. Holding `int1` high causes only one burst. An edge that arrives while `busy` is high does not trigger a burst.
- R9: The six burst bytes are X low, X high, Y low, Y high, Z low, Z high. Each output is {high, low}. After the frame ends, `smp_vld` pulses for exactly one cycle while chip select is high, and the outputs hold their values until the next burst.
- R10: `busy` is high from reset until setup ends and whenever a frame is in progress. It is low while the block waits for an interrupt edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miso | input | 1 | Serial data from the sensor |
| int1 | input | 1 | Data-ready interrupt from the sensor (asynchronous) |
| sclk | output | 1 | Serial clock, rests high |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the sensor |
| busy | output | 1 | High while starting up or during a transaction |
| link_err | output | 1 | Sticky identity-mismatch flag |
| smp_vld | output | 1 | One-cycle strobe when a new sample set is ready |
| smp_x | output | 16 | X-axis sample, two's complement |
| smp_y | output | 16 | Y-axis sample, two's complement |
| smp_z | output | 16 | Z-axis sample, two's complement |

## Verification
The assertions check the following on every cycle:
- SCLK rests high outside a frame, and SCLK falls only while chip select is low.
- Chip select never falls before the power-up delay has passed.
- `busy` is high whenever chip select is low.
- Once set, `link_err` does not clear.
- The valid strobe lasts one cycle and appears only between frames.

Some behaviours can only be shown by the bench's scenarios, because they depend on the byte content of each frame and on the order of the frames. These are:
- the command and data bytes of each frame, and the order of the setup writes;
- how the six burst bytes are joined into the three axis words;
- that a held level or an edge arriving mid-burst does not start an extra frame.

// File: rtl/accel_spi_pkg.sv
// Shared constants, state encodings and the command-byte builder for the
// accelerometer SPI controller. Assumes a 6-bit register address space.
package accel_spi_pkg;

    // Which register transaction the sequencer is running
    typedef enum logic [2:0] {TX_ID, TX_W0, TX_W1, TX_W2, TX_RD} txn_e;

    // Sequencer states
    typedef enum logic [2:0] {S_PWR, S_SEL, S_LAUNCH, S_XFER, S_GAP, S_IDLE} seq_st_e;

    localparam logic [7:0] ID_EXPECT   = 8'hE6;
    localparam logic [5:0] A_DEVID     = 6'h00;
    localparam logic [5:0] A_FMT       = 6'h31;
    localparam logic [5:0] A_PWR       = 6'h2D;
    localparam logic [5:0] A_IEN       = 6'h2E;
    localparam logic [5:0] A_AXIS      = 6'h32;
    localparam logic [7:0] V_FMT       = 8'h0B;
    localparam logic [7:0] V_PWR       = 8'h08;
    localparam logic [7:0] V_IEN       = 8'h80;
    localparam int         BURST_BYTES = 6;
    localparam int         AXES        = 3;

    // Command byte: bit 7 read, bit 6 multi-byte, bits 5:0 start address
    function automatic logic [7:0] cmd_byte(input logic rd, input logic mb,
                                            input logic [5:0] addr);
        return {rd, mb, addr};
    endfunction

endpackage

// File: rtl/accel_spi_byte.sv
// One-byte mode-3 shift engine. On `start` it sends `tx` MSB first:
// SCLK falls and MOSI updates, then after CLK_DIV clocks SCLK rises and
// MISO is sampled. `done` pulses once the eighth high phase ends.
// Assumes `start` comes only while idle and CLK_DIV >= 1.
module accel_spi_byte #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);
    localparam int CW = $clog2(CLK_DIV + 1);

    logic          active;
    logic          hi_ph;
    logic [2:0]    bit_i;
    logic [CW-1:0] cnt;
    logic [7:0]    sh;

    // Bit timing, shifting out and sampling in
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            hi_ph  <= 1'b0;
            bit_i  <= '0;
            cnt    <= '0;
            sh     <= '0;
            rx     <= '0;
            sclk   <= 1'b1;
            mosi   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    hi_ph  <= 1'b0;
                    cnt    <= '0;
                    bit_i  <= 3'd7;
                    sh     <= {tx[6:0], 1'b0};
                    mosi   <= tx[7];
                    sclk   <= 1'b0;
                end
            end else if (cnt == CW'(CLK_DIV - 1)) begin
                cnt <= '0;
                if (!hi_ph) begin
                    sclk  <= 1'b1;
                    hi_ph <= 1'b1;
                    rx    <= {rx[6:0], miso};
                end else if (bit_i == 3'd0) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    bit_i <= bit_i - 3'd1;
                    hi_ph <= 1'b0;
                    sclk  <= 1'b0;
                    mosi  <= sh[7];
                    sh    <= {sh[6:0], 1'b0};
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/accel_spi_seq.sv
// Transaction sequencer. It waits for the power-up delay, runs the identity
// read and the three setup writes, and then turns each synchronised rising
// edge of int1 into one burst read. It owns chip select and the
// identity-mismatch flag, and reports every received byte with its position.
// Assumes the byte engine acknowledges each start with exactly one done.
module accel_spi_seq
    import accel_spi_pkg::*;
#(
    parameter int WAIT_CYC = 110000,
    parameter int CLK_DIV  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       int1,
    input  logic       byte_done,
    input  logic [7:0] rx_byte,
    output logic       byte_start,
    output logic [7:0] tx_byte,
    output logic       cs_n,
    output logic       busy,
    output logic       link_err,
    output logic       rx_vld,
    output logic [2:0] rx_idx,
    output logic       commit
);
    localparam int WCW = $clog2(WAIT_CYC + 1);
    localparam int GCW = $clog2(CLK_DIV + 1);

    seq_st_e        st;
    txn_e           txn;
    txn_e           nxt_txn;
    logic [2:0]     idx;
    logic [2:0]     last_idx;
    logic [WCW-1:0] wcnt;
    logic [GCW-1:0] gcnt;
    logic           i_s1, i_s2, i_s3;
    logic           int_rise;
    logic           gap_end;
    logic [7:0]     cmd;
    logic [7:0]     wdat;

    // Per-transaction command, data byte, length and successor
    always_comb begin
        cmd     = cmd_byte(1'b1, 1'b0, A_DEVID);
        wdat    = 8'h00;
        nxt_txn = TX_W0;
        unique case (txn)
            TX_ID: begin cmd = cmd_byte(1'b1, 1'b0, A_DEVID); nxt_txn = TX_W0; end
            TX_W0: begin cmd = cmd_byte(1'b0, 1'b0, A_FMT); wdat = V_FMT; nxt_txn = TX_W1; end
            TX_W1: begin cmd = cmd_byte(1'b0, 1'b0, A_PWR); wdat = V_PWR; nxt_txn = TX_W2; end
            TX_W2: begin cmd = cmd_byte(1'b0, 1'b0, A_IEN); wdat = V_IEN; nxt_txn = TX_W2; end
            TX_RD: begin cmd = cmd_byte(1'b1, 1'b1, A_AXIS); nxt_txn = TX_RD; end
            default: ;
        endcase
    end

    // Byte-level outputs towards the shift engine and the sample packer
    always_comb begin
        last_idx   = (txn == TX_RD) ? 3'(BURST_BYTES) : 3'd1;
        tx_byte    = (idx == 3'd0) ? cmd : wdat;
        byte_start = (st == S_LAUNCH);
        rx_vld     = (st == S_XFER) && byte_done;
        rx_idx     = idx;
        int_rise   = i_s2 && !i_s3;
        gap_end    = (st == S_GAP) && (gcnt == GCW'(CLK_DIV - 1));
        commit     = gap_end && (txn == TX_RD);
        busy       = (st != S_IDLE);
    end

    // Main sequencing, chip select framing and int1 synchroniser
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_PWR;
            txn      <= TX_ID;
            idx      <= '0;
            wcnt     <= '0;
            gcnt     <= '0;
            cs_n     <= 1'b1;
            link_err <= 1'b0;
            i_s1     <= 1'b0;
            i_s2     <= 1'b0;
            i_s3     <= 1'b0;
        end else begin
            {i_s3, i_s2, i_s1} <= {i_s2, i_s1, int1};
            unique case (st)
                S_PWR: begin
                    if (wcnt == WCW'(WAIT_CYC - 1)) st <= S_SEL;
                    else wcnt <= wcnt + 1'b1;
                end
                S_SEL: begin
                    cs_n <= 1'b0;
                    idx  <= '0;
                    st   <= S_LAUNCH;
                end
                S_LAUNCH: st <= S_XFER;
                S_XFER: begin
                    if (byte_done) begin
                        if (idx == last_idx) begin
                            cs_n <= 1'b1;
                            gcnt <= '0;
                            st   <= S_GAP;
                            if (txn == TX_ID && rx_byte != ID_EXPECT) link_err <= 1'b1;
                        end else begin
                            idx <= idx + 3'd1;
                            st  <= S_LAUNCH;
                        end
                    end
                end
                S_GAP: begin
                    if (gap_end) begin
                        if (txn == TX_W2 || txn == TX_RD) begin
                            st <= S_IDLE;
                        end else begin
                            txn <= nxt_txn;
                            st  <= S_SEL;
                        end
                    end else begin
                        gcnt <= gcnt + 1'b1;
                    end
                end
                S_IDLE: begin
                    if (int_rise) begin
                        txn <= TX_RD;
                        st  <= S_SEL;
                    end
                end
                default: st <= S_PWR;
            endcase
        end
    end
endmodule

// File: rtl/accel_sample_pack.sv
// Sample assembler. It stores the burst bytes by their frame position
// (1..6 = X lo, X hi, Y lo, Y hi, Z lo, Z hi). On `commit` it loads each
// axis word as {hi, lo} and pulses `vld` for one cycle.
// Assumes position 0 is the command byte and is discarded.
module accel_sample_pack
    import accel_spi_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bvld,
    input  logic [2:0]  bidx,
    input  logic [7:0]  bdata,
    input  logic        commit,
    output logic [15:0] x,
    output logic [15:0] y,
    output logic [15:0] z,
    output logic        vld
);
    logic [7:0]  raw [BURST_BYTES];
    logic [15:0] ax  [AXES];

    // Capture received bytes into their slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BURST_BYTES; i++) raw[i] <= '0;
        end else if (bvld && bidx != 3'd0 && bidx <= 3'(BURST_BYTES)) begin
            raw[bidx - 3'd1] <= bdata;
        end
    end

    // Join byte pairs into axis words and strobe valid
    generate
        for (genvar g = 0; g < AXES; g++) begin : g_axis
            always_ff @(posedge clk) begin
                if (!rst_n)      ax[g] <= '0;
                else if (commit) ax[g] <= {raw[2*g+1], raw[2*g]};
            end
        end
    endgenerate

    // One-cycle valid pulse after commit
    always_ff @(posedge clk) begin
        if (!rst_n) vld <= 1'b0;
        else        vld <= commit;
    end

    assign x = ax[0];
    assign y = ax[1];
    assign z = ax[2];
endmodule

// File: rtl/accel_spi_ctrl.sv
// Top level of the accelerometer SPI bring-up and sample streamer. It wires
// the sequencer, the mode-3 byte engine and the sample assembler together.
// Assumes int1 is asynchronous to clk and that miso changes on falling SCLK.
module accel_spi_ctrl #(
    parameter int CLK_DIV  = 4,
    parameter int WAIT_CYC = 110000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        miso,
    input  logic        int1,
    output logic        sclk,
    output logic        cs_n,
    output logic        mosi,
    output logic        busy,
    output logic        link_err,
    output logic        smp_vld,
    output logic [15:0] smp_x,
    output logic [15:0] smp_y,
    output logic [15:0] smp_z
);
    logic       byte_start;
    logic       byte_done;
    logic [7:0] tx_byte;
    logic [7:0] rx_byte;
    logic       rx_vld;
    logic [2:0] rx_idx;
    logic       commit;

    accel_spi_seq #(.WAIT_CYC(WAIT_CYC), .CLK_DIV(CLK_DIV)) u_seq (
        .clk(clk), .rst_n(rst_n), .int1(int1),
        .byte_done(byte_done), .rx_byte(rx_byte),
        .byte_start(byte_start), .tx_byte(tx_byte),
        .cs_n(cs_n), .busy(busy), .link_err(link_err),
        .rx_vld(rx_vld), .rx_idx(rx_idx), .commit(commit)
    );

    accel_spi_byte #(.CLK_DIV(CLK_DIV)) u_byte (
        .clk(clk), .rst_n(rst_n), .start(byte_start), .tx(tx_byte),
        .miso(miso), .sclk(sclk), .mosi(mosi), .done(byte_done), .rx(rx_byte)
    );

    accel_sample_pack u_pack (
        .clk(clk), .rst_n(rst_n), .bvld(rx_vld), .bidx(rx_idx),
        .bdata(rx_byte), .commit(commit),
        .x(smp_x), .y(smp_y), .z(smp_z), .vld(smp_vld)
    );
endmodule

// File: rtl/accel_spi_ctrl_chk.sv
// Property checker for accel_spi_ctrl, attached with bind. It watches the
// serial framing, the power-up delay, busy coverage, the sticky error flag
// and the valid strobe. Assumes synchronous active-low reset.
module accel_spi_ctrl_chk #(
    parameter int WAIT_CYC = 110000
) (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic cs_n,
    input logic busy,
    input logic link_err,
    input logic smp_vld
);
    logic [31:0] since_rst;

    // Saturating count of clocks since reset release
    always_ff @(posedge clk) begin
        if (!rst_n)                    since_rst <= '0;
        else if (since_rst != '1)      since_rst <= since_rst + 32'd1;
    end

    a_r1_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);
    a_r1_sclk_falls_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> !cs_n);
    a_r2_power_wait: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> (since_rst >= 32'(WAIT_CYC)));
    a_r4_link_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        link_err |=> link_err);
    a_r9_vld_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> !smp_vld);
    a_r9_vld_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |-> cs_n);
    a_r10_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);
endmodule

bind accel_spi_ctrl accel_spi_ctrl_chk #(.WAIT_CYC(WAIT_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .busy(busy), .link_err(link_err), .smp_vld(smp_vld)
);

// File: tb/accel_spi_ctrl_bench.sv
// Bench for accel_spi_ctrl. A behavioural sensor model answers on the
// serial bus and logs every frame. Expected samples wait in a queue, and
// the per-clock comparisons run at each falling clk edge.
module accel_spi_ctrl_bench;
    localparam int CLK_DIV  = 2;
    localparam int WAIT_CYC = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        int1 = 1'b0;
    logic        miso_r = 1'b0;
    logic        sclk, cs_n, mosi, busy, link_err, smp_vld;
    logic [15:0] smp_x, smp_y, smp_z;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    accel_spi_ctrl #(.CLK_DIV(CLK_DIV), .WAIT_CYC(WAIT_CYC)) u_accel_spi_ctrl (
        .clk(clk), .rst_n(rst_n), .miso(miso_r), .int1(int1),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .busy(busy),
        .link_err(link_err), .smp_vld(smp_vld),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z)
    );

    // ---------------- sensor model ----------------
    logic [7:0] fb [0:63][0:7];
    int         flen [0:63];
    int         nframes = 0;
    int         bitpos = 0;
    bit         in_frame = 0;
    logic       prev_cs = 1'b1, prev_sclk = 1'b1;
    logic [7:0] in_sh = 8'h00;
    logic [7:0] id_val = 8'hE6;
    logic [7:0] sbytes [0:5];
    logic [7:0] rbyte;

    always @(cs_n or sclk) begin
        if (prev_cs === 1'b1 && cs_n === 1'b0) begin
            in_frame = 1; bitpos = 0; in_sh = 8'h00; flen[nframes % 64] = 0; miso_r = 1'b0;
        end else if (prev_cs === 1'b0 && cs_n === 1'b1 && in_frame) begin
            in_frame = 0; nframes++;
        end
        if (in_frame && prev_sclk === 1'b1 && sclk === 1'b0) begin
            rbyte = 8'h00;
            if (bitpos / 8 >= 1) begin
                if (fb[nframes % 64][0] == 8'h80) rbyte = id_val;
                else if (fb[nframes % 64][0] == 8'hF2 && bitpos / 8 <= 6) rbyte = sbytes[bitpos / 8 - 1];
            end
            miso_r = rbyte[7 - (bitpos % 8)];
        end
        if (in_frame && prev_sclk === 1'b0 && sclk === 1'b1) begin
            in_sh = {in_sh[6:0], mosi};
            bitpos++;
            if (bitpos % 8 == 0 && bitpos / 8 <= 8) begin
                fb[nframes % 64][bitpos / 8 - 1] = in_sh;
                flen[nframes % 64] = bitpos / 8;
            end
        end
        prev_cs = cs_n; prev_sclk = sclk;
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [47:0] exp_q[$];
    int          base = 0;
    logic [7:0]  run_id = 8'hE6;
    int          vld_cnt = 0;

    // Per-clock reference comparison
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            if (cs_n) chk("R1 sclk idle high", 64'(sclk), 64'd1);
            if (!cs_n) chk("R10 busy during frame", 64'(busy), 64'd1);
            chk("R4 link_err model", 64'(link_err),
                64'((nframes > base) && (run_id != 8'hE6)));
            if (smp_vld) begin
                vld_cnt++;
                if (exp_q.size() == 0) chk("R9 unexpected valid", 64'd1, 64'd0);
                else chk("R9 sample words", {16'h0, smp_x, smp_y, smp_z}, {16'h0, exp_q.pop_front()});
                chk("R9 valid outside frame", 64'(cs_n), 64'd1);
            end
        end
    end

    task automatic do_reset(input logic [7:0] idv);
        @(negedge clk);
        rst_n = 1'b0; int1 = 1'b0; id_val = idv;
        repeat (3) @(negedge clk);
        chk("R1 reset cs_n", 64'(cs_n), 64'd1);
        chk("R1 reset sclk", 64'(sclk), 64'd1);
        chk("R9 reset valid", 64'(smp_vld), 64'd0);
        chk("R4 reset link_err", 64'(link_err), 64'd0);
        chk("R10 reset busy", 64'(busy), 64'd1);
        base = nframes; run_id = idv;
        rst_n = 1'b1;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 20000) begin @(negedge clk); n++; end
    endtask

    task automatic chk_frame(input string req, input int f, input int len, input logic [55:0] exp);
        logic [55:0] act = '0;
        for (int i = 0; i < 7; i++) if (i < flen[f % 64]) act[8*(6-i) +: 8] = fb[f % 64][i];
        chk({req, " length"}, 64'(flen[f % 64]), 64'(len));
        chk({req, " bytes"}, {8'h0, act}, {8'h0, exp});
    endtask

    task automatic burst(input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
        int n = 0;
        sbytes[0] = x[7:0]; sbytes[1] = x[15:8];
        sbytes[2] = y[7:0]; sbytes[3] = y[15:8];
        sbytes[4] = z[7:0]; sbytes[5] = z[15:8];
        exp_q.push_back({x, y, z});
        @(negedge clk); int1 = 1'b1;
        while (!busy && n < 50) begin @(negedge clk); n++; end
        wait_idle();
        repeat (4) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        int f0, t;
        for (int i = 0; i < 6; i++) sbytes[i] = 8'h00;
        do_reset(8'hE6);
        t = 0;
        while (cs_n && t < 5000) begin @(negedge clk); t++; end
        chk("R2 power-up wait honoured", 64'(t >= WAIT_CYC), 64'd1);
        wait_idle();
        chk("R6 four setup frames", 64'(nframes - base), 64'd4);
        chk_frame("R3 identity read", base, 2, 56'h80_00_0000000000);
        chk_frame("R5 write 1", base + 1, 2, 56'h31_0B_0000000000);
        chk_frame("R5 write 2", base + 2, 2, 56'h2D_08_0000000000);
        chk_frame("R5 write 3", base + 3, 2, 56'h2E_80_0000000000);
        chk("R4 matched id no error", 64'(link_err), 64'd0);
        chk("R10 idle not busy", 64'(busy), 64'd0);

        // R7 burst, int1 held high afterwards (R8 level)
        f0 = nframes;
        burst(16'h0FFF, 16'hF000, 16'h0100);
        chk_frame("R7 burst frame", f0, 7, 56'hF2_000000000000);
        repeat (300) @(negedge clk);
        chk("R8 held level gives one burst", 64'(nframes - f0), 64'd1);
        chk("R9 one valid per burst", 64'(vld_cnt), 64'd1);
        chk("R9 outputs held", {16'h0, smp_x, smp_y, smp_z}, 64'h0FFF_F000_0100);

        // Second pattern
        int1 = 1'b0; repeat (10) @(negedge clk);
        burst(16'hFFFF, 16'h0001, 16'hF123);
        chk("R7 second burst count", 64'(nframes - f0), 64'd2);

        // R8 edge during busy ignored
        int1 = 1'b0; repeat (10) @(negedge clk);
        sbytes[0] = 8'h34; sbytes[1] = 8'h12; sbytes[2] = 8'h78;
        sbytes[3] = 8'h56; sbytes[4] = 8'hCD; sbytes[5] = 8'hFA;
        exp_q.push_back({16'h1234, 16'h5678, 16'hFACD});
        @(negedge clk); int1 = 1'b1;
        t = 0;
        while (cs_n && t < 100) begin @(negedge clk); t++; end
        repeat (20) @(negedge clk); int1 = 1'b0;
        repeat (20) @(negedge clk); int1 = 1'b1;
        wait_idle();
        repeat (400) @(negedge clk);
        chk("R8 edge while busy ignored", 64'(nframes - f0), 64'd3);
        chk("R9 all samples delivered", 64'(exp_q.size()), 64'd0);

        // Mismatched identity: error sticks, setup still runs
        do_reset(8'h00);
        wait_idle();
        chk("R4 mismatch sets error", 64'(link_err), 64'd1);
        chk("R5 setup after mismatch", 64'(nframes - base), 64'd4);
        f0 = nframes;
        burst(16'h0002, 16'hFFFE, 16'h0000);
        chk("R4 error sticky over burst", 64'(link_err), 64'd1);
        chk_frame("R6 burst own frame", f0, 7, 56'hF2_000000000000);
        chk("R9 final queue empty", 64'(exp_q.size()), 64'd0);

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule